// File: doc/BRIEF.md
# Keyed Write-Once Watchdog Timer

A watchdog peripheral with a small register interface. A slow-clock enable strobe, arriving in the system clock domain, is divided by a prescaler into a tick. Each tick decrements a 12-bit down-counter. When the counter runs out, the watchdog may issue a single-cycle reset request. That request goes either to a processor-only reset output or to the full system reset output.

Software configures the watchdog once through a mode word. The hardware accepts the first write after reset and locks the word from then on. Software keeps the system alive by writing a restart command that carries a key byte. A restart is legal only while the counter has fallen to or below a programmable window value. A restart that arrives too early counts as a fault. A debug input can freeze the watchdog while the debug-freeze mode bit is set. If software never writes the mode word, the reset defaults keep the watchdog running at its longest timeout.

Top module: `kwdt_top`

## Requirements
- R1: The prescaler counts slow-clock enable strobes. One counter tick occurs on every PRESC_DIV-th strobe (default 128), and the counter decrements by one per tick. While `slow_en_i` is low, nothing advances.
- R2: The counter is reloaded from reload field bits [11:0] in three cases: a mode write, an accepted restart and an underflow. Each reload also clears the prescaler. A reset request is visible on the outputs exactly (reload+1)*PRESC_DIV strobes after the reload.
- R3: The mode word is at address 1. Only the first write after reset is stored. Later writes leave its readback value and the running timeout unchanged.
- R4: A write to address 0 restarts the counter only when bits [31:24] equal 0xA5 and bit 0 is set. Any other control write has no effect.
- R5: While disable bit 15 of the mode word is set, the counter and prescaler hold, keyed restarts are ignored, and no reset request is produced.
- R6: A request is produced only while reset-enable bit 13 is set. The request is a one-cycle pulse on `cpu_rst_o` when bit 14 is set, and otherwise on `sys_rst_o`. The two outputs are never high together.
- R7: While debug-freeze bit 28 is set and `dbg_i` is high, the counter and prescaler hold. Each frozen cycle delays the request by one cycle. When bit 28 is clear, `dbg_i` has no effect.
- R8: A keyed restart is accepted only when the counter is at or below window field bits [27:16]. An early restart sets the window-error flag. When reset-enable is set, an early restart also issues a request on the next cycle and reloads the counter. When reset-enable is clear, the counter is left untouched.
- R9: Reading address 2 returns the underflow flag in bit 0, the window-error flag in bit 1 and the current counter in bits [27:16]. Both flags are sticky and clear on that read.
- R10: After reset, the mode word reads 0x0FFF2FFF: reload 0xFFF, window 0xFFF, reset-enable set. Without any write, the watchdog requests a system reset 4096*PRESC_DIV strobes after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_en_i | input | 1 | One-cycle strobe per slow-clock period |
| dbg_i | input | 1 | Debugger halt indication |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears status on address 2) |
| addr_i | input | 2 | Register address: 0 control, 1 mode, 2 status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| sys_rst_o | output | 1 | Full system reset request pulse |
| cpu_rst_o | output | 1 | Processor-only reset request pulse |

## Verification
The bound checker watches several properties on every cycle:
- the two reset outputs stay mutually exclusive;
- no request appears while the watchdog is disabled;
- the mode word stays frozen once it is locked;
- the counter holds during a debug freeze and steps down by exactly one per tick;
- an underflow reloads the counter from the reload field;
- the sticky underflow flag persists until it is read.

End-to-end timing can only be shown by the bench's scenarios. These cover:
- the (reload+1)*PRESC_DIV timeout over a sweep of reload values and both reset routes;
- stretched timeouts under a sparse slow-clock strobe and under debug freeze;
- keyed versus unkeyed restarts;
- early versus in-window restarts with reset-enable set and clear;
- the write-once lock and the unattended default timeout.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int unsigned CNT_W   = 12;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  localparam logic [7:0] KEY_VAL   = 8'hA5;
  localparam int unsigned KEY_LSB  = 24;
  localparam int unsigned RESTART_BIT = 0;

  localparam int unsigned RELOAD_LSB = 0;
  localparam int unsigned RST_EN_BIT = 13;
  localparam int unsigned CPU_SEL_BIT = 14;
  localparam int unsigned DIS_BIT    = 15;
  localparam int unsigned WIN_LSB    = 16;
  localparam int unsigned DBG_BIT    = 28;

  localparam int unsigned UF_BIT     = 0;
  localparam int unsigned WERR_BIT   = 1;
  localparam int unsigned CNT_LSB    = 16;

  typedef struct packed {
    logic             dbg_frz;
    logic [CNT_W-1:0] win;
    logic             dis;
    logic             cpu_sel;
    logic             rst_en;
    logic [CNT_W-1:0] reload;
  } mode_t;

  localparam mode_t MODE_RST = '{dbg_frz: 1'b0, win: {CNT_W{1'b1}}, dis: 1'b0,
                                 cpu_sel: 1'b0, rst_en: 1'b1, reload: {CNT_W{1'b1}}};

  function automatic mode_t unpack_mode(input logic [BUS_W-1:0] w);
    mode_t m;
    m.reload  = w[RELOAD_LSB +: CNT_W];
    m.win     = w[WIN_LSB +: CNT_W];
    m.rst_en  = w[RST_EN_BIT];
    m.cpu_sel = w[CPU_SEL_BIT];
    m.dis     = w[DIS_BIT];
    m.dbg_frz = w[DBG_BIT];
    return m;
  endfunction

  function automatic logic [BUS_W-1:0] pack_mode(input mode_t m);
    logic [BUS_W-1:0] w;
    w = '0;
    w[RELOAD_LSB +: CNT_W] = m.reload;
    w[WIN_LSB +: CNT_W]    = m.win;
    w[RST_EN_BIT]          = m.rst_en;
    w[CPU_SEL_BIT]         = m.cpu_sel;
    w[DIS_BIT]             = m.dis;
    w[DBG_BIT]             = m.dbg_frz;
    return w;
  endfunction
endpackage

// File: rtl/kwdt_presc.sv
module kwdt_presc #(
  parameter int unsigned PRESC_DIV = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic slow_en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned PW = (PRESC_DIV > 2) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESC_DIV - 1);

  logic [PW-1:0] pre_q;
  logic          step;

  assign step   = run_i & slow_en_i;
  assign tick_o = step & (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clr_i)   pre_q <= '0;
    else if (step)    pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '1;
    else if (load_i)  cnt_q <= load_val_i;
    else if (tick_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              uf_evt_i,
  input  logic              werr_evt_i,
  output mode_t             mode_o,
  output mode_t             mode_d_o,
  output logic              mode_wr_o,
  output logic              restart_o,
  output logic              locked_o,
  output logic              uf_flag_o,
  output logic              stat_rd_o,
  output logic [BUS_W-1:0]  rdata_o
);
  mode_t mode_q;
  logic  locked_q, uf_q, werr_q;
  logic  unused_wbits;

  assign unused_wbits = ^wdata_i;
  assign mode_d_o  = unpack_mode(wdata_i);
  assign mode_wr_o = wr_en_i & (addr_i == ADDR_MODE) & ~locked_q;
  assign restart_o = wr_en_i & (addr_i == ADDR_CTRL) & wdata_i[RESTART_BIT]
                   & (wdata_i[KEY_LSB +: 8] == KEY_VAL);
  assign stat_rd_o = rd_en_i & (addr_i == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_RST;
      locked_q <= 1'b0;
    end else if (mode_wr_o) begin
      mode_q   <= mode_d_o;
      locked_q <= 1'b1;
    end
  end

  // set wins over read-clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uf_q   <= 1'b0;
      werr_q <= 1'b0;
    end else begin
      uf_q   <= uf_evt_i   | (uf_q   & ~stat_rd_o);
      werr_q <= werr_evt_i | (werr_q & ~stat_rd_o);
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_MODE: rdata_o = pack_mode(mode_q);
      ADDR_STAT: begin
        rdata_o[UF_BIT]            = uf_q;
        rdata_o[WERR_BIT]          = werr_q;
        rdata_o[CNT_LSB +: CNT_W]  = cnt_i;
      end
      default:   rdata_o = '0;
    endcase
  end

  assign mode_o    = mode_q;
  assign locked_o  = locked_q;
  assign uf_flag_o = uf_q;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned PRESC_DIV = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_en_i,
  input  logic              dbg_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              sys_rst_o,
  output logic              cpu_rst_o
);
  mode_t            mode, mode_d;
  logic             mode_wr, restart_req, locked, uf_flag, stat_rd;
  logic             frz_act, run, tick, zero, in_win;
  logic             restart_ok, werr_evt, uf_evt, fire, load;
  logic [CNT_W-1:0] cnt, load_val;
  logic             sys_q, cpu_q;

  kwdt_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .uf_evt_i(uf_evt), .werr_evt_i(werr_evt),
    .mode_o(mode), .mode_d_o(mode_d), .mode_wr_o(mode_wr),
    .restart_o(restart_req), .locked_o(locked), .uf_flag_o(uf_flag),
    .stat_rd_o(stat_rd), .rdata_o
  );

  assign frz_act    = mode.dbg_frz & dbg_i;
  assign run        = ~mode.dis & ~frz_act;
  assign in_win     = (cnt <= mode.win);
  assign restart_ok = restart_req & ~mode.dis & in_win;
  assign werr_evt   = restart_req & ~mode.dis & ~in_win;
  assign uf_evt     = tick & zero & ~mode_wr & ~restart_ok;
  assign fire       = mode.rst_en & (uf_evt | werr_evt);
  assign load       = mode_wr | restart_ok | uf_evt | fire;
  assign load_val   = mode_wr ? mode_d.reload : mode.reload;

  kwdt_presc #(.PRESC_DIV(PRESC_DIV)) u_presc (
    .clk_i, .rst_ni, .run_i(run), .slow_en_i, .clr_i(load), .tick_o(tick)
  );

  kwdt_count #(.W(CNT_W)) u_count (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val),
    .tick_i(tick), .cnt_o(cnt), .zero_o(zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_q <= 1'b0;
      cpu_q <= 1'b0;
    end else begin
      sys_q <= fire & ~mode.cpu_sel;
      cpu_q <= fire &  mode.cpu_sel;
    end
  end

  assign sys_rst_o = sys_q;
  assign cpu_rst_o = cpu_q;
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
  import kwdt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input mode_t            mode,
  input logic             locked,
  input logic [CNT_W-1:0] cnt,
  input logic             tick,
  input logic             load,
  input logic             frz_act,
  input logic             mode_wr,
  input logic             restart_ok,
  input logic             uf_flag,
  input logic             stat_rd,
  input logic             sys_rst_o,
  input logic             cpu_rst_o
);
  // R6
  rst_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sys_rst_o && cpu_rst_o));

  // R5
  dis_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode.dis && $past(mode.dis)) |-> (!sys_rst_o && !cpu_rst_o));

  // R3
  mode_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && $past(locked)) |-> $stable(mode));

  // R7
  frz_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_act && !load) |=> $stable(cnt));

  // R1
  tick_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R2
  uf_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt == '0 && !mode_wr && !restart_ok) |=> (cnt == $past(mode.reload)));

  // R9
  uf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_flag && !stat_rd) |=> uf_flag);
endmodule

bind kwdt_top kwdt_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode(mode), .locked(locked), .cnt(cnt),
  .tick(tick), .load(load), .frz_act(frz_act), .mode_wr(mode_wr),
  .restart_ok(restart_ok), .uf_flag(uf_flag), .stat_rd(stat_rd),
  .sys_rst_o(sys_rst_o), .cpu_rst_o(cpu_rst_o)
);

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_en = 1'b1, dbg = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sys_rst, cpu_rst;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  kwdt_top #(.PRESC_DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .slow_en_i(slow_en), .dbg_i(dbg),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sys_rst_o(sys_rst), .cpu_rst_o(cpu_rst)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int r, input int w, input bit en,
                                     input bit cpu, input bit dis, input bit frz);
    return (32'(r) & 32'hFFF) | (32'(en) << 13) | (32'(cpu) << 14) |
           (32'(dis) << 15) | ((32'(w) & 32'hFFF) << 16) | (32'(frz) << 28);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; rd_en = 0; dbg = 0; slow_en = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  // counts edges after the current point until a request shows; n=0 if none
  task automatic wait_pulse(input int max_cyc, input bit gap, input int frz_n,
                            output int n, output bit s, output bit c);
    n = 0; s = 0; c = 0;
    slow_en = gap ? 1'b0 : 1'b1;
    dbg = (frz_n > 0);
    for (int i = 1; i <= max_cyc; i++) begin
      @(posedge clk); #1;
      if (sys_rst || cpu_rst) begin
        n = i; s = sys_rst; c = cpu_rst;
        break;
      end
      slow_en = gap ? ((i % 2) == 1) : 1'b1;
      dbg = (i < frz_n);
    end
    slow_en = 1'b1; dbg = 1'b0;
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    int n; bit s, c; logic [31:0] d, d2;

    // R10 reset state
    do_reset();
    chk("R10 outputs idle", {sys_rst, cpu_rst}, 0);
    bus_rd(2'd1, d);
    chk("R10 mode default", d, 32'h0FFF2FFF);
    bus_rd(2'd2, d);
    chk("R10 flags clear", d[1:0], 0);

    // R10 unattended default timeout
    do_reset();
    wait_pulse(20000, 0, 0, n, s, c);
    chk("R10 default timeout", n, 4096 * DIV);
    chk("R10 default route sys", {s, c}, 2'b10);

    // R2 R6 sweep of reload and route
    for (int r = 0; r < 8; r++) begin
      for (int cp = 0; cp < 2; cp++) begin
        do_reset();
        bus_wr(2'd1, mk(r, 12'hFFF, 1, cp[0], 0, 0));
        wait_pulse(200, 0, 0, n, s, c);
        chk($sformatf("R2 timeout r=%0d", r), n, (r + 1) * DIV);
        chk($sformatf("R6 route cpu=%0d", cp), {s, c}, cp[0] ? 2'b01 : 2'b10);
        if (r == 3) begin
          @(posedge clk); #1;
          chk("R6 single cycle", {sys_rst, cpu_rst}, 0);
        end
      end
    end

    // R1 sparse slow strobe doubles the timeout
    for (int r = 2; r < 6; r += 3) begin
      do_reset();
      bus_wr(2'd1, mk(r, 12'hFFF, 1, 0, 0, 0));
      wait_pulse(400, 1, 0, n, s, c);
      chk($sformatf("R1 sparse strobe r=%0d", r), n, 2 * (r + 1) * DIV);
    end

    // R3 write-once
    do_reset();
    bus_wr(2'd1, mk(3, 12'hFFF, 1, 0, 0, 0));
    bus_wr(2'd1, mk(50, 12'h010, 1, 1, 1, 1));
    wait_pulse(400, 0, 0, n, s, c);
    chk("R3 second write ignored timing", n, 4 * DIV - 1);
    chk("R3 second write ignored route", {s, c}, 2'b10);
    bus_rd(2'd1, d);
    chk("R3 readback first value", d, mk(3, 12'hFFF, 1, 0, 0, 0));

    // R4 keyed restart and rejected control writes
    do_reset();
    bus_wr(2'd1, mk(6, 12'hFFF, 1, 0, 0, 0));
    repeat (10) @(posedge clk);
    bus_wr(2'd0, 32'hA5000001);
    wait_pulse(200, 0, 0, n, s, c);
    chk("R4 keyed restart", n, 7 * DIV);
    do_reset();
    bus_wr(2'd1, mk(6, 12'hFFF, 1, 0, 0, 0));
    repeat (10) @(posedge clk);
    bus_wr(2'd0, 32'h5A000001);
    wait_pulse(200, 0, 0, n, s, c);
    chk("R4 wrong key ignored", n, 7 * DIV - 11);
    do_reset();
    bus_wr(2'd1, mk(6, 12'hFFF, 1, 0, 0, 0));
    repeat (10) @(posedge clk);
    bus_wr(2'd0, 32'hA5000000);
    wait_pulse(200, 0, 0, n, s, c);
    chk("R4 missing restart bit ignored", n, 7 * DIV - 11);

    // R5 disabled
    do_reset();
    bus_wr(2'd1, mk(2, 12'hFFF, 1, 0, 1, 0));
    wait_pulse(300, 0, 0, n, s, c);
    chk("R5 no request when disabled", n, 0);
    bus_wr(2'd0, 32'hA5000001);
    bus_rd(2'd2, d);
    chk("R5 counter held", d[27:16], 2);
    chk("R5 restart ignored no error", d[1:0], 0);

    // R7 debug freeze
    do_reset();
    bus_wr(2'd1, mk(4, 12'hFFF, 1, 0, 0, 1));
    wait_pulse(300, 0, 13, n, s, c);
    chk("R7 freeze delays", n, 5 * DIV + 13);
    do_reset();
    bus_wr(2'd1, mk(4, 12'hFFF, 1, 0, 0, 0));
    wait_pulse(300, 0, 13, n, s, c);
    chk("R7 dbg ignored without bit", n, 5 * DIV);

    // R8 early restart with reset enabled
    do_reset();
    bus_wr(2'd1, mk(20, 5, 1, 0, 0, 0));
    bus_wr(2'd0, 32'hA5000001);
    chk("R8 early restart request", {sys_rst, cpu_rst}, 2'b10);
    bus_rd(2'd2, d);
    chk("R8 window error flag", d[1], 1);
    bus_rd(2'd2, d2);
    chk("R9 flag cleared by read", d2[1:0], 0);

    // R8 in-window restart accepted
    do_reset();
    bus_wr(2'd1, mk(20, 5, 1, 0, 0, 0));
    repeat (70) @(posedge clk);
    bus_wr(2'd0, 32'hA5000001);
    wait_pulse(200, 0, 0, n, s, c);
    chk("R8 in-window restart", n, 21 * DIV);
    bus_rd(2'd2, d);
    chk("R9 underflow flag no error", d[1:0], 2'b01);

    // R8 R6 early restart with reset disabled
    do_reset();
    bus_wr(2'd1, mk(20, 5, 0, 0, 0, 0));
    bus_wr(2'd0, 32'hA5000001);
    chk("R6 no request when not enabled", {sys_rst, cpu_rst}, 0);
    bus_rd(2'd2, d);
    chk("R8 error flag without reset", d[1], 1);
    wait_pulse(200, 0, 0, n, s, c);
    chk("R6 underflow silent", n, 0);
    bus_rd(2'd2, d);
    chk("R9 underflow flag sticky", d[1:0], 2'b01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule